// File: doc/BRIEF.md
# Bus Request Grant Handshake Controller

This block decides who owns a processor's external bus. An outside master asks for the bus by pulling an active-low request pin. The pin is asynchronous, so it is first brought into the clock domain. The controller then lets the processor finish any bus cycle already under way. It turns off the drivers of the seven bus strobes and drives the active-low grant only after that. When the master lets go of the request, the grant is removed first. The strobes come back one guard interval later.

A second active-low output, the hung flag, tells the outside master that the core is stalled. It goes low while the bus is granted away and the core reports that it needs the bus to continue. Every pin is a plain level control: no data flows through the block, so there is no valid/ready handshake and no back-pressure. The strobe enables come straight from a Gray-coded state register, so each edge moves at most one state bit.

Top module: `busgrant_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, every strobe enable is 1 (driven), the grant output is 1 and the hung output is 1.
- R2: The request is seen through a two-flop synchronizer. If the request pin goes low ahead of a rising edge E1, the strobe enables all drop to 0 on the third rising edge counted from E1. Until then the outputs keep their idle values.
- R3: The strobes are released before the grant. For GUARD_CYCLES clocks (1 by default) all strobe enables are 0 and the grant is still 1; the grant then goes low. Strobe enable bits are ordered [0] program select, [1] data select, [2] cache select, [3] I/O select, [4] boot select, [5] read, [6] write. All seven move together, and 1 means the strobe is driven.
- R4: While the request stays low, the grant stays low and the strobe enables stay 0.
- R5: If the request pin goes high ahead of a rising edge E1, the grant returns to 1 on the third rising edge counted from E1. The strobe enables return to 1 GUARD_CYCLES clocks after that.
- R6: The hung output is 0 exactly in the cycles where the grant is low and core_need is 1. It follows core_need within the same cycle. core_need has no effect on any output while the bus is not granted.
- R7: While core_busy is 1 the controller stays idle, with the strobes driven and the grant high, whatever the request does. The release starts on the first rising edge at which core_busy is 0 and the synchronized request is present.
- R8: A request held low for only one clock still runs the whole handshake. Each of the release, granted and reclaim phases lasts at least one clock before the controller returns to idle.
- R9: If the request comes back during the reclaim phase, the strobes are re-driven for at least one clock before a new release starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_n | input | 1 | Asynchronous active-low bus request from the outside master |
| core_need | input | 1 | Core needs the external bus to continue |
| core_busy | input | 1 | Core bus cycle in flight; holds off a release |
| strobe_en | output | NUM_STROBES (7) | Output enables of the select, read and write strobes, 1 = driven |
| bus_grant_n | output | 1 | Active-low bus grant |
| grant_hung_n | output | 1 | Active-low flag: core stalled while the bus is granted |

## Verification
The handshake is driven with several request patterns. A long request checks the synchronizer latency and that the strobes are released ahead of the grant. A release checks that the grant is removed before the strobes are re-driven. A one-clock pulse shows whether each phase still lasts its minimum time. A request that returns during reclaim shows whether the controller passes through idle before it releases again. core_need is raised both while granted and while idle, which separates a hung flag gated by the grant from one that follows the core's flag alone. A request raised while core_busy is high shows whether an in-flight cycle really blocks the release.

// File: rtl/bg_pkg.sv
package bg_pkg;
  // Gray-coded ownership states: every legal transition flips one bit.
  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_RELEASE = 2'b01,
    ST_GRANTED = 2'b11,
    ST_RECLAIM = 2'b10
  } bg_state_e;
endpackage

// File: rtl/bg_sync.sv
module bg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/bg_fsm.sv
module bg_fsm
  import bg_pkg::*;
#(
  parameter int GUARD_CYCLES = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_sync,
  input  logic      core_busy,
  output bg_state_e state
);
  localparam int CW = (GUARD_CYCLES > 1) ? $clog2(GUARD_CYCLES) : 1;
  localparam logic [CW-1:0] GUARD_LOAD = CW'(GUARD_CYCLES - 1);

  bg_state_e     nxt;
  logic [CW-1:0] guard_cnt;
  logic          guard_done;

  assign guard_done = (guard_cnt == '0);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:    if (req_sync && !core_busy) nxt = ST_RELEASE;
      ST_RELEASE: if (guard_done)             nxt = ST_GRANTED;
      ST_GRANTED: if (!req_sync)              nxt = ST_RECLAIM;
      ST_RECLAIM: if (guard_done)             nxt = ST_IDLE;
      default:                                nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      guard_cnt <= GUARD_LOAD;
    end else begin
      state <= nxt;
      if (nxt != state)        guard_cnt <= GUARD_LOAD;
      else if (!guard_done)    guard_cnt <= guard_cnt - 1'b1;
    end
  end

  // R7: an in-flight core cycle keeps the bus with the processor
  p_busy_holds_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && core_busy) |=> (state == ST_IDLE));

  // R9: reclaim can only finish into idle, never straight into a new release
  p_reclaim_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECLAIM) |=> (state == ST_RECLAIM || state == ST_IDLE));

  // R3: each edge moves at most one state bit, so the decoded pins cannot glitch
  p_gray_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(2'(state) ^ 2'($past(state))) <= 1);

  // R8: the granted phase is only entered from release
  p_granted_from_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |=> (state != ST_GRANTED));
endmodule

// File: rtl/bg_drive.sv
module bg_drive
  import bg_pkg::*;
#(
  parameter int NUM_STROBES = 7
) (
  input  bg_state_e              state,
  input  logic                   core_need,
  output logic [NUM_STROBES-1:0] strobe_en,
  output logic                   bus_grant_n,
  output logic                   grant_hung_n
);
  logic own_bus;
  logic granted;

  assign own_bus = (state == ST_IDLE);
  assign granted = (state == ST_GRANTED);

  for (genvar i = 0; i < NUM_STROBES; i++) begin : g_strobe
    assign strobe_en[i] = own_bus;
  end

  assign bus_grant_n  = !granted;
  assign grant_hung_n = !(granted && core_need);
endmodule

// File: rtl/busgrant_ctrl.sv
module busgrant_ctrl
  import bg_pkg::*;
#(
  parameter int NUM_STROBES  = 7,
  parameter int SYNC_STAGES  = 2,
  parameter int GUARD_CYCLES = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_req_n,
  input  logic                   core_need,
  input  logic                   core_busy,
  output logic [NUM_STROBES-1:0] strobe_en,
  output logic                   bus_grant_n,
  output logic                   grant_hung_n
);
  logic      req_sync;
  bg_state_e state;

  bg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (!bus_req_n),
    .sync_out (req_sync)
  );

  bg_fsm #(.GUARD_CYCLES(GUARD_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_sync  (req_sync),
    .core_busy (core_busy),
    .state     (state)
  );

  bg_drive #(.NUM_STROBES(NUM_STROBES)) u_drive (
    .state        (state),
    .core_need    (core_need),
    .strobe_en    (strobe_en),
    .bus_grant_n  (bus_grant_n),
    .grant_hung_n (grant_hung_n)
  );

  // R3: the grant falls only after a cycle with every strobe released
  p_grant_after_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_grant_n) |-> ($past(strobe_en) == '0 && strobe_en == '0));

  // R5: the strobes return only after the grant was already high
  p_strobes_after_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_en[0]) |-> ($past(bus_grant_n) && bus_grant_n));

  // R6: the hung flag needs the grant and released strobes
  p_hung_while_granted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_hung_n |-> (!bus_grant_n && strobe_en == '0));

  // R4: while granted, no strobe is driven
  p_grant_no_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_grant_n |-> (strobe_en == '0));
endmodule

// File: tb/busgrant_ctrl_tb.sv
module busgrant_ctrl_tb;
  localparam int NS   = 7;
  localparam int G    = 1;
  localparam int LAT  = 3;   // two synchronizer flops plus the state register

  typedef struct {
    int          cyc;
    bit          on;
    bit          gn;
    bit          hn;
    string       tag;
  } exp_t;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          bus_req_n = 1;
  logic          core_need = 0;
  logic          core_busy = 0;
  logic [NS-1:0] strobe_en;
  logic          bus_grant_n;
  logic          grant_hung_n;

  int   cyc = 0;
  int   last = 0;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  busgrant_ctrl #(.NUM_STROBES(NS), .SYNC_STAGES(2), .GUARD_CYCLES(G)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req_n    (bus_req_n),
    .core_need    (core_need),
    .core_busy    (core_busy),
    .strobe_en    (strobe_en),
    .bus_grant_n  (bus_grant_n),
    .grant_hung_n (grant_hung_n)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(bit on, bit gn, bit hn, string tag);
    logic [NS-1:0] es;
    es = on ? '1 : '0;
    n_vec++;
    if (strobe_en !== es || bus_grant_n !== gn || grant_hung_n !== hn) begin
      n_bad++;
      $display("FAIL %s cyc %0d: strobe_en=%b grant_n=%b hung_n=%b expected %b %b %b",
               tag, cyc, strobe_en, bus_grant_n, grant_hung_n, es, gn, hn);
    end
  endtask

  task automatic push(int from, int to, bit on, bit gn, bit hn, string tag);
    for (int k = from; k <= to; k++) begin
      exp_t e;
      e.cyc = k; e.on = on; e.gn = gn; e.hn = hn; e.tag = tag;
      q.push_back(e);
    end
    if (to > last) last = to;
  endtask

  task automatic drain;
    while (cyc <= last) @(negedge clk);
  endtask

  // monitor: compares the queue front against the pins, away from the edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (rst_n && q.size() > 0 && q[0].cyc <= cyc) begin
        exp_t e;
        e = q.pop_front();
        if (e.cyc == cyc) check(e.on, e.gn, e.hn, e.tag);
        else begin
          n_vec++; n_bad++;
          $display("FAIL %s cyc %0d: item for cycle %0d never sampled, expected %b %b %b",
                   e.tag, cyc, e.cyc, e.on, e.gn, e.hn);
        end
      end
    end
  end

  // driver
  initial begin
    int c;
    repeat (3) @(negedge clk);
    #2 check(1, 1, 1, "R1");           // during reset
    @(negedge clk);
    rst_n = 1;
    push(cyc, cyc + 2, 1, 1, 1, "R1");
    drain();

    // R2 / R3 / R4: long request
    c = cyc; bus_req_n = 0;
    push(c, c + LAT - 1, 1, 1, 1, "R2");
    push(c + LAT, c + LAT + G - 1, 0, 1, 1, "R3");
    push(c + LAT + G, c + LAT + G + 4, 0, 0, 1, "R4");
    drain();

    // R6: core stalls while granted
    c = cyc; core_need = 1;
    push(c, c + 2, 0, 0, 0, "R6");
    repeat (3) @(negedge clk);
    core_need = 0;
    push(cyc, cyc + 1, 0, 0, 1, "R6");
    drain();

    // R5: release
    c = cyc; bus_req_n = 1;
    push(c, c + LAT - 1, 0, 0, 1, "R5");
    push(c + LAT, c + LAT + G - 1, 0, 1, 1, "R5");
    push(c + LAT + G, c + LAT + G + 2, 1, 1, 1, "R5");
    drain();

    // R6: core_need has no effect while the processor owns the bus
    c = cyc; core_need = 1;
    push(c, c + 3, 1, 1, 1, "R6");
    drain();
    core_need = 0;

    // R7: core busy blocks the release
    c = cyc; core_busy = 1; bus_req_n = 0;
    push(c, c + 6, 1, 1, 1, "R7");
    repeat (6) @(negedge clk);
    c = cyc; core_busy = 0;
    push(c + 1, c + G, 0, 1, 1, "R7");
    push(c + 1 + G, c + G + 3, 0, 0, 1, "R7");
    drain();
    c = cyc; bus_req_n = 1;
    push(c, c + LAT - 1, 0, 0, 1, "R5");
    push(c + LAT, c + LAT + G - 1, 0, 1, 1, "R5");
    push(c + LAT + G, c + LAT + G + 2, 1, 1, 1, "R5");
    drain();

    // R8: one-clock request pulse
    c = cyc; bus_req_n = 0;
    push(c, c + LAT - 1, 1, 1, 1, "R8");
    push(c + LAT, c + LAT + G - 1, 0, 1, 1, "R8");
    push(c + LAT + G, c + LAT + G, 0, 0, 1, "R8");
    push(c + LAT + G + 1, c + LAT + 2 * G, 0, 1, 1, "R8");
    push(c + LAT + 2 * G + 1, c + LAT + 2 * G + 3, 1, 1, 1, "R8");
    @(negedge clk);
    bus_req_n = 1;
    drain();

    // R9: request returns during reclaim
    c = cyc; bus_req_n = 0;
    push(c, c + LAT - 1, 1, 1, 1, "R2");
    push(c + LAT, c + LAT + G - 1, 0, 1, 1, "R3");
    push(c + LAT + G, c + LAT + G + 2, 0, 0, 1, "R4");
    drain();
    c = cyc; bus_req_n = 1;
    push(c, c + LAT - 1, 0, 0, 1, "R9");
    push(c + LAT, c + LAT + G - 1, 0, 1, 1, "R9");
    push(c + LAT + G, c + LAT + G, 1, 1, 1, "R9");
    push(c + LAT + G + 1, c + LAT + 2 * G, 0, 1, 1, "R9");
    push(c + LAT + 2 * G + 1, c + LAT + 2 * G + 3, 0, 0, 1, "R9");
    @(negedge clk);
    bus_req_n = 0;
    drain();
    c = cyc; bus_req_n = 1;
    push(c, c + LAT - 1, 0, 0, 1, "R5");
    push(c + LAT, c + LAT + G - 1, 0, 1, 1, "R5");
    push(c + LAT + G, c + LAT + G + 2, 1, 1, 1, "R5");
    drain();

    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // watchdog
  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: run hung at cyc %0d, expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule